// File: doc/BRIEF.md
# Multi-Sequence Command Sequencer

This block holds a shared command memory and four sequence descriptors. The host fills the memory in two steps. It first loads a write-pointer register, then writes a data word, and that word lands at the location the pointer names. Each descriptor gives a start address and a command count for one sequence. Several sequences can live side by side in the memory. The hardware does not check whether their ranges overlap, so keeping them apart is the host's job.

A one-cycle request on `seq_req[k]` starts sequence k, provided the engine is idle. The engine copies the descriptor at the start edge, then reads commands in order from the start address. The address wraps modulo the memory depth. Each command is presented on a valid/ready dispatch port, at most one per cycle.

Back-pressure rules for the dispatch port:
- While `cmd_valid` is high and `cmd_ready` is low, the word and its sequence tag are held unchanged.
- A command is consumed only on a cycle where both `cmd_valid` and `cmd_ready` are high.

Other behaviour:
- A request that arrives while a sequence runs is dropped, not queued, and raises a per-sequence "ignored" flag.
- Each finished sequence raises a per-sequence "done" flag.
- Both flag sets are sticky until the host writes 1 to clear them.

Top module: `cmd_seq_top`

## Requirements
- R1: After reset `cmd_valid`, `busy`, `irq_done` and `irq_ign` are all 0.
- R2: `waddr_we` loads the write pointer from `waddr_in`. `wdata_we` stores `wdata_in` at memory location `pointer mod 2^MEM_AW`, using the pointer value held before that clock edge, so a pointer load in the same cycle takes effect only for later writes.
- R3: `desc_we` writes descriptor `desc_sel`. The start address is `desc_wdata[10:0]` and the command count is `desc_wdata[26:16]`. All other bits of `desc_wdata` are ignored.
- R4: A started sequence with count N > 0 dispatches exactly N commands: `mem[(start+i) mod 2^MEM_AW]` for i = 0..N-1, in that order, each with `cmd_seq` equal to the sequence index. The first `cmd_valid` appears one cycle after the edge that sampled the request.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data` and `cmd_seq` hold. With `cmd_ready` held high, one command is accepted every cycle.
- R6: A request for a sequence whose count is 0 dispatches nothing and leaves `busy` low. Its done flag is set at the edge that samples the request.
- R7: A request sampled while `busy` is high is ignored and sets `irq_ign[k]` for each requested k. This includes the cycle of the final handshake, and a request for the running sequence itself. The running sequence is unaffected.
- R8: When several requests are sampled while idle, the lowest index starts and every other requested index sets its ignored flag.
- R9: At the edge of a sequence's final handshake, `busy` falls and `irq_done[k]` is set.
- R10: With `irq_clr_we` high, flags whose bit is 1 in `irq_clr_done` or `irq_clr_ign` are cleared. A flag that is set and cleared in the same cycle ends up set.
- R11: The descriptor is latched at start, so descriptor writes during a run affect only later starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| waddr_we | input | 1 | Load write pointer |
| waddr_in | input | 11 | Write pointer value |
| wdata_we | input | 1 | Store command word at write pointer |
| wdata_in | input | CMD_W | Command word |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | SEQ_W | Descriptor index |
| desc_wdata | input | 32 | Descriptor word (start [10:0], count [26:16]) |
| seq_req | input | NUM_SEQ | Sequence start requests |
| cmd_valid | output | 1 | Dispatch word valid |
| cmd_ready | input | 1 | Dispatch consumer ready |
| cmd_data | output | CMD_W | Dispatched command |
| cmd_seq | output | SEQ_W | Sequence the command belongs to |
| busy | output | 1 | A sequence is running |
| irq_done | output | NUM_SEQ | Sticky end-of-sequence flags |
| irq_ign | output | NUM_SEQ | Sticky ignored-request flags |
| irq_clr_we | input | 1 | Flag clear strobe |
| irq_clr_done | input | NUM_SEQ | Write-1 clear mask for done flags |
| irq_clr_ign | input | NUM_SEQ | Write-1 clear mask for ignored flags |

## Verification
The sharpest collision is a new request landing in the same cycle as the running sequence's final handshake. The bench counts accepted commands and raises the request exactly when the last one is on the port with `cmd_ready` high. It then expects the ignored flag for the new sequence, the done flag for the old one, and no extra commands. A second collision sets and clears the same ignored flag in one cycle, and the flag is expected to read as set. The requests are raised while another sequence is stalled under slow `cmd_ready`.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int FIELD_W   = 11;
  localparam int START_LSB = 0;
  localparam int COUNT_LSB = 16;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t start;
    field_t count;
  } desc_t;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_RUN = 1'b1} eng_state_e;

  function automatic desc_t unpack_desc(input logic [31:0] w);
    desc_t d;
    d.start = w[START_LSB +: FIELD_W];
    d.count = w[COUNT_LSB +: FIELD_W];
    return d;
  endfunction
endpackage

// File: rtl/cmd_seq_mem.sv
module cmd_seq_mem
  import cmd_seq_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              waddr_we,
  input  field_t            waddr_in,
  input  logic              wdata_we,
  input  logic [CMD_W-1:0]  wdata_in,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [CMD_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << MEM_AW;

  field_t           wptr_q;
  logic [CMD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)        wptr_q <= '0;
    else if (waddr_we) wptr_q <= waddr_in;
  end

  // host side only writes; engine side only reads
  always_ff @(posedge clk) begin
    if (wdata_we) store[wptr_q[MEM_AW-1:0]] <= wdata_in;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/cmd_seq_desc.sv
module cmd_seq_desc
  import cmd_seq_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_we,
  input  logic [SEQ_W-1:0] desc_sel,
  input  logic [31:0]      desc_wdata,
  input  logic [SEQ_W-1:0] rd_sel,
  output desc_t            rd_desc
);
  desc_t [NUM_SEQ-1:0] table_q;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_entry
    desc_t entry_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q <= '0;
      else if (desc_we && desc_sel == SEQ_W'(g))
        entry_q <= unpack_desc(desc_wdata);
    end
    assign table_q[g] = entry_q;
  end

  assign rd_desc = table_q[rd_sel];
endmodule

// File: rtl/cmd_seq_arb.sv
module cmd_seq_arb #(
  parameter int NUM_SEQ = 4,
  parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEQ-1:0] seq_req,
  input  logic               busy,
  output logic               start,
  output logic [SEQ_W-1:0]   start_id,
  output logic [NUM_SEQ-1:0] ign_set
);
  always_comb begin
    start    = 1'b0;
    start_id = '0;
    if (!busy) begin
      for (int i = NUM_SEQ - 1; i >= 0; i--) begin
        if (seq_req[i]) begin
          start    = 1'b1;
          start_id = SEQ_W'(i);
        end
      end
    end
    ign_set = seq_req;
    if (start) ign_set[start_id] = 1'b0;
  end

  // R8
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (seq_req & ((NUM_SEQ'(1) << start_id) - NUM_SEQ'(1))) == '0);
endmodule

// File: rtl/cmd_seq_engine.sv
module cmd_seq_engine
  import cmd_seq_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int CMD_W   = 32,
  parameter int MEM_AW  = 6,
  parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEQ_W-1:0]   start_id,
  input  desc_t              start_desc,
  output logic [MEM_AW-1:0]  rd_addr,
  input  logic [CMD_W-1:0]   rd_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [CMD_W-1:0]   cmd_data,
  output logic [SEQ_W-1:0]   cmd_seq,
  output logic               busy,
  output logic [NUM_SEQ-1:0] done_set
);
  localparam logic [MEM_AW-1:0] PTR_ONE = MEM_AW'(1);
  localparam field_t            REM_ONE = field_t'(1);

  eng_state_e        state_q;
  logic [MEM_AW-1:0] ptr_q;
  field_t            rem_q;
  logic [SEQ_W-1:0]  cur_q;
  logic              slot_free, can_load, finish, zero_start;

  assign slot_free  = !cmd_valid || cmd_ready;
  assign can_load   = (state_q == ENG_RUN) && (rem_q != '0) && slot_free;
  assign finish     = (state_q == ENG_RUN) && (rem_q == '0) && slot_free;
  assign zero_start = start && (start_desc.count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      ptr_q     <= '0;
      rem_q     <= '0;
      cur_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else if (state_q == ENG_IDLE) begin
      if (start && !zero_start) begin
        state_q <= ENG_RUN;
        ptr_q   <= start_desc.start[MEM_AW-1:0];
        rem_q   <= start_desc.count;
        cur_q   <= start_id;
      end
    end else begin
      if (can_load) begin
        cmd_data  <= rd_data;
        cmd_valid <= 1'b1;
        ptr_q     <= ptr_q + PTR_ONE;
        rem_q     <= rem_q - REM_ONE;
      end else if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
      end
      if (finish) state_q <= ENG_IDLE;
    end
  end

  always_comb begin
    done_set = '0;
    if (finish)          done_set[cur_q]    = 1'b1;
    else if (zero_start) done_set[start_id] = 1'b1;
  end

  assign rd_addr = ptr_q;
  assign cmd_seq = cur_q;
  assign busy    = (state_q == ENG_RUN);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_seq));
  // R4
  valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  // R7
  seq_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(cmd_seq));
  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && start_desc.count == '0 |=> !busy && !cmd_valid);
endmodule

// File: rtl/cmd_seq_top.sv
module cmd_seq_top
  import cmd_seq_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int CMD_W   = 32,
  parameter int MEM_AW  = 6,
  parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               waddr_we,
  input  logic [10:0]        waddr_in,
  input  logic               wdata_we,
  input  logic [CMD_W-1:0]   wdata_in,
  input  logic               desc_we,
  input  logic [SEQ_W-1:0]   desc_sel,
  input  logic [31:0]        desc_wdata,
  input  logic [NUM_SEQ-1:0] seq_req,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [CMD_W-1:0]   cmd_data,
  output logic [SEQ_W-1:0]   cmd_seq,
  output logic               busy,
  output logic [NUM_SEQ-1:0] irq_done,
  output logic [NUM_SEQ-1:0] irq_ign,
  input  logic               irq_clr_we,
  input  logic [NUM_SEQ-1:0] irq_clr_done,
  input  logic [NUM_SEQ-1:0] irq_clr_ign
);
  logic [MEM_AW-1:0]  rd_addr;
  logic [CMD_W-1:0]   rd_data;
  logic               start;
  logic [SEQ_W-1:0]   start_id;
  desc_t              start_desc;
  logic [NUM_SEQ-1:0] ign_set, done_set;
  logic [NUM_SEQ-1:0] clr_done_m, clr_ign_m;

  cmd_seq_mem #(.CMD_W(CMD_W), .MEM_AW(MEM_AW)) mem_i (
    .clk(clk), .rst_n(rst_n), .waddr_we(waddr_we), .waddr_in(waddr_in),
    .wdata_we(wdata_we), .wdata_in(wdata_in), .rd_addr(rd_addr), .rd_data(rd_data));

  cmd_seq_desc #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) desc_i (
    .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_sel(desc_sel),
    .desc_wdata(desc_wdata), .rd_sel(start_id), .rd_desc(start_desc));

  cmd_seq_arb #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .busy(busy),
    .start(start), .start_id(start_id), .ign_set(ign_set));

  cmd_seq_engine #(.NUM_SEQ(NUM_SEQ), .CMD_W(CMD_W), .MEM_AW(MEM_AW), .SEQ_W(SEQ_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_id(start_id), .start_desc(start_desc),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_seq(cmd_seq), .busy(busy), .done_set(done_set));

  assign clr_done_m = irq_clr_we ? irq_clr_done : '0;
  assign clr_ign_m  = irq_clr_we ? irq_clr_ign  : '0;

  // new events take precedence over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_done <= '0;
      irq_ign  <= '0;
    end else begin
      irq_done <= (irq_done & ~clr_done_m) | done_set;
      irq_ign  <= (irq_ign  & ~clr_ign_m)  | ign_set;
    end
  end

  // R7
  ign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (seq_req != '0) |=> (irq_ign & $past(seq_req)) == $past(seq_req));
  // R9
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_done != '0);
endmodule

// File: tb/cmd_seq_top_tb_top.sv
module cmd_seq_top_tb_top;
  localparam int NS = 4;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        waddr_we = 1'b0, wdata_we = 1'b0, desc_we = 1'b0;
  logic [10:0] waddr_in = '0;
  logic [31:0] wdata_in = '0, desc_wdata = '0;
  logic [1:0]  desc_sel = '0;
  logic [3:0]  seq_req = '0;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_data;
  logic [1:0]  cmd_seq;
  logic        busy;
  logic [3:0]  irq_done, irq_ign;
  logic        irq_clr_we = 1'b0;
  logic [3:0]  irq_clr_done = '0, irq_clr_ign = '0;

  cmd_seq_top #(.NUM_SEQ(NS), .CMD_W(32), .MEM_AW(AW)) dut_i (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int stall_errs = 0, stall_checks = 0;
  int cap_n = 0;
  logic [31:0] cap_d [256];
  logic [1:0]  cap_s [256];
  logic [31:0] exp_mem [DEPTH];
  int st_tab [NS];
  int cnt_tab [NS];
  int rdy_mode = 0;
  int cyc = 0;
  bit done_rep = 1'b0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_d = '0;
  logic [1:0]  prev_s = '0;

  // ready pattern driven away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (rdy_mode)
      0: cmd_ready <= 1'b1;
      1: cmd_ready <= cyc[0];
      default: cmd_ready <= (cyc % 3) == 2;
    endcase
  end

  // capture handshakes and check the hold rule under back-pressure
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        stall_checks <= stall_checks + 1;
        if (!cmd_valid || cmd_data !== prev_d || cmd_seq !== prev_s) begin
          stall_errs <= stall_errs + 1;
          $display("FAIL R5 stall hold: got v=%0b d=%h s=%0d exp v=1 d=%h s=%0d",
                   cmd_valid, cmd_data, cmd_seq, prev_d, prev_s);
        end
      end
      prev_stall <= cmd_valid && !cmd_ready;
      prev_d <= cmd_data;
      prev_s <= cmd_seq;
      if (cmd_valid && cmd_ready) begin
        cap_d[cap_n % 256] <= cmd_data;
        cap_s[cap_n % 256] <= cmd_seq;
        cap_n <= cap_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_rep) begin
      done_rep = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors + stall_errs, checks + stall_checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return {8'hC3, 8'(a), 16'(a * 37 + 5)};
  endfunction

  task automatic write_cmd(input int a, input logic [31:0] d);
    @(negedge clk);
    waddr_we = 1'b1; waddr_in = 11'(a);
    @(negedge clk);
    waddr_we = 1'b0; wdata_we = 1'b1; wdata_in = d;
    @(negedge clk);
    wdata_we = 1'b0;
    exp_mem[a % DEPTH] = d;
  endtask

  // junk bits outside the two fields must be ignored (R3)
  task automatic write_desc(input int id, input int st, input int cnt);
    @(negedge clk);
    desc_we = 1'b1; desc_sel = 2'(id);
    desc_wdata = {5'h1F, 11'(cnt), 5'h15, 11'(st)};
    @(negedge clk);
    desc_we = 1'b0;
    st_tab[id] = st % DEPTH; cnt_tab[id] = cnt;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    irq_clr_we = 1'b1; irq_clr_done = '1; irq_clr_ign = '1;
    @(negedge clk);
    irq_clr_we = 1'b0; irq_clr_done = '0; irq_clr_ign = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic check_run(input int id, input int base, input int cnt, input int st);
    chk(cap_n - base == cnt, "R4 command count", 32'(cap_n - base), 32'(cnt));
    for (int i = 0; i < cnt && i < cap_n - base; i++) begin
      chk(cap_d[(base + i) % 256] === exp_mem[(st + i) % DEPTH], "R4 command order",
          cap_d[(base + i) % 256], exp_mem[(st + i) % DEPTH]);
      chk(cap_s[(base + i) % 256] === 2'(id), "R4 sequence tag",
          32'(cap_s[(base + i) % 256]), 32'(id));
    end
    chk(irq_done[id] === 1'b1, "R9 done flag", 32'(irq_done), 32'(1 << id));
    chk(!busy && !cmd_valid, "R9 idle after end", {30'b0, busy, cmd_valid}, 32'h0);
  endtask

  task automatic run_seq(input int id);
    int base;
    base = cap_n;
    @(negedge clk);
    seq_req = 4'(1 << id);
    @(negedge clk);
    seq_req = '0;
    wait_idle();
    @(negedge clk);
    check_run(id, base, cnt_tab[id], st_tab[id]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1
    chk(cmd_valid === 1'b0 && busy === 1'b0, "R1 reset outputs", {30'b0, cmd_valid, busy}, 32'h0);
    chk(irq_done === 4'h0 && irq_ign === 4'h0, "R1 reset flags", {24'b0, irq_done, irq_ign}, 32'h0);
    rst_n = 1'b1;

    for (int a = 0; a < DEPTH; a++) write_cmd(a, pat(a));
    write_desc(0, 0, 5);
    write_desc(1, 10, 3);
    write_desc(2, 20, 0);
    write_desc(3, 2044, 6);  // low address bits 60: wraps past the end (R4)

    // sweep every sequence under every ready pattern (R4, R5, R9)
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      for (int id = 0; id < NS; id++) begin
        clear_flags();
        base = cap_n;
        if (cnt_tab[id] == 0) begin
          // R6
          @(negedge clk); seq_req = 4'(1 << id);
          @(negedge clk); seq_req = '0;
          chk(irq_done[id] === 1'b1 && busy === 1'b0, "R6 zero count done", {27'b0, busy, irq_done}, 32'(1 << id));
          repeat (3) @(negedge clk);
          chk(cap_n == base && !cmd_valid, "R6 zero count no output", 32'(cap_n - base), 32'h0);
        end else begin
          run_seq(id);
        end
      end
    end

    // R7: requests while busy, plus set-and-clear in one cycle (R10)
    clear_flags();
    rdy_mode = 2;
    base = cap_n;
    @(negedge clk); seq_req = 4'b0001;
    @(negedge clk); seq_req = 4'b0011;
    @(negedge clk); seq_req = '0;
    chk(irq_ign === 4'b0011, "R7 ignored flags", 32'(irq_ign), 32'h3);
    @(negedge clk);
    seq_req = 4'b0100; irq_clr_we = 1'b1; irq_clr_ign = 4'b0101;
    @(negedge clk);
    seq_req = '0; irq_clr_we = 1'b0; irq_clr_ign = '0;
    chk(irq_ign === 4'b0110, "R10 set beats clear", 32'(irq_ign), 32'h6);
    wait_idle();
    @(negedge clk);
    check_run(0, base, 5, 0);
    chk(irq_done === 4'b0001, "R7 only running seq done", 32'(irq_done), 32'h1);

    // R10 plain write-1 clear of selected bits
    @(negedge clk);
    irq_clr_we = 1'b1; irq_clr_done = 4'b0001; irq_clr_ign = 4'b0010;
    @(negedge clk);
    irq_clr_we = 1'b0; irq_clr_done = '0; irq_clr_ign = '0;
    chk(irq_done === 4'h0 && irq_ign === 4'b0100, "R10 selective clear", {24'b0, irq_done, irq_ign}, 32'h04);
    // R10 flags stay set without a clear strobe
    @(negedge clk); irq_clr_ign = 4'b1111;
    @(negedge clk); irq_clr_ign = '0;
    chk(irq_ign === 4'b0100, "R10 mask needs strobe", 32'(irq_ign), 32'h4);

    // R7: request in the very cycle of the final handshake
    clear_flags();
    rdy_mode = 0;
    base = cap_n;
    @(negedge clk); seq_req = 4'b0010;
    @(negedge clk); seq_req = '0;
    while (!(cap_n - base == 2 && cmd_valid && cmd_ready)) @(negedge clk);
    seq_req = 4'b1000;
    @(negedge clk);
    seq_req = '0;
    chk(irq_ign === 4'b1000, "R7 last-handshake request ignored", 32'(irq_ign), 32'h8);
    chk(busy === 1'b0, "R9 busy falls at last handshake", 32'(busy), 32'h0);
    repeat (3) @(negedge clk);
    check_run(1, base, 3, 10);

    // R8: simultaneous requests while idle
    clear_flags();
    base = cap_n;
    @(negedge clk); seq_req = 4'b1010;
    @(negedge clk); seq_req = '0;
    chk(irq_ign === 4'b1000, "R8 loser flagged", 32'(irq_ign), 32'h8);
    wait_idle();
    @(negedge clk);
    check_run(1, base, 3, 10);

    // R11: descriptor rewritten during a run
    clear_flags();
    rdy_mode = 1;
    base = cap_n;
    @(negedge clk); seq_req = 4'b0001;
    @(negedge clk); seq_req = '0;
    write_desc(0, 0, 2);
    wait_idle();
    @(negedge clk);
    check_run(0, base, 5, 0);
    clear_flags();
    run_seq(0);  // R11 new count applies at the next start

    // R2: pointer load and data write in the same cycle
    @(negedge clk); waddr_we = 1'b1; waddr_in = 11'd10;
    @(negedge clk); waddr_in = 11'd11; wdata_we = 1'b1; wdata_in = 32'h5EED_0010;
    @(negedge clk); waddr_we = 1'b0; wdata_we = 1'b0;
    exp_mem[10] = 32'h5EED_0010;
    // R2: upper pointer bits fold onto the memory depth
    @(negedge clk); wdata_we = 1'b1; wdata_in = 32'h5EED_0011;
    @(negedge clk); wdata_we = 1'b0;
    exp_mem[11] = 32'h5EED_0011;
    write_cmd(12 + DEPTH * 5, 32'h5EED_0012);
    clear_flags();
    run_seq(1);

    report();
  end
endmodule